// File: doc/BRIEF.md
# Serial Bit-Position Trigger

This block watches one asynchronous serial line and produces a single-cycle trigger pulse at a chosen bit boundary inside a frame, instead of at the frame's first edge. Placing the event late in the frame, for example where the stop bit begins, removes the variable time a sender takes to shift the byte out. That variable delay would otherwise show up as jitter in anything timed from the trigger.

Control logic loads a bit-period divisor, a frame format and a target boundary index, then pulses `arm_i`. This is normally done after an earlier byte has gone out and before the byte of interest starts. The block then waits for a falling edge on the idle-high line and confirms it at mid-bit. It counts whole bit periods from that edge and fires once when the count reaches the target. It then stays in a fired state and ignores the line until it is armed again.

Top module: `uart_bit_trigger`

## Requirements
- R1: After reset `trig_o` is 0 and `status_o` reads 0 (idle). The status codes are: 0 idle, 1 armed, 2 busy, 3 fired.
- R2: A cycle with `arm_i` high and `disarm_i` low makes `status_o` read 1 (armed) from the next cycle. A cycle with `disarm_i` high makes it read 0 (idle) from the next cycle, even if `arm_i` is also high.
- R3: When armed, the line is synchronized through two flops and a falling edge on it is detected. `trig_o` then rises 2 + k·D clock edges after the edge at which the line was first sampled low, where D is the armed divisor (4 or more) and k is the effective target.
- R4: `trig_o` is high for exactly one clock cycle per arming, and `status_o` reads 3 (fired) from that same cycle.
- R5: The number of slots in a frame is 7 + code + parity + two_stop. Here `data_code_i` selects 5 + code data bits, `parity_en_i` adds one parity slot and `two_stop_i` adds a second stop slot. 8E1 is code 3, parity 1, two_stop 0, which gives 11 slots, and target 10 marks the start of its stop bit.
- R6: The effective target k is 1 when `target_i` is 0, and equals the slot count when `target_i` exceeds that count. Otherwise k equals `target_i`.
- R7: A low pulse that is no longer low when sampled at mid-bit (D/2 periods after detection) is rejected. No trigger follows, the status returns to 1 (armed), and a later real frame still fires.
- R8: While idle or fired, activity on the line produces no trigger and leaves the status unchanged.
- R9: Asserting `disarm_i` during a frame in progress aborts it. No trigger is produced and the status reads 0.
- R10: Divisor, format and target are captured at arming. Changing the inputs afterwards does not affect the frame being timed.
- R11: Between the confirmed start edge and the trigger, `status_o` reads 2 (busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Observed serial line, idle high, asynchronous |
| arm_i | input | 1 | One-cycle arm request; captures the configuration |
| disarm_i | input | 1 | Abort and return to idle; wins over arm_i |
| div_i | input | DIV_W | Bit period in clock cycles (4 or more) |
| data_code_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Frame carries a parity slot |
| two_stop_i | input | 1 | Frame carries two stop slots |
| target_i | input | 4 | Bit boundary index to fire at |
| trig_o | output | 1 | One-cycle trigger pulse |
| status_o | output | 2 | 0 idle, 1 armed, 2 busy, 3 fired |

## Verification
The bench builds the block with `DIV_W` = 4, so divisors stay at 4, 5 and 8 clocks and a whole frame lasts under a hundred cycles. That makes it cheap to sweep every target value from 0 to 15 against four frame formats and three divisors. Every clamp case and the exact trigger cycle are then compared against 3 + k·D computed in the bench. The same small divisor brings mid-bit rejection, aborts and out-of-state line activity into a few cycles each.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
  localparam int SLOT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_CONFIRM, ST_BUSY, ST_FIRED
  } state_e;

  typedef enum logic [1:0] {
    STAT_IDLE  = 2'd0,
    STAT_ARMED = 2'd1,
    STAT_BUSY  = 2'd2,
    STAT_FIRED = 2'd3
  } status_e;
endpackage

// File: rtl/uart_trig_sync.sv
module uart_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic ff1_q, ff2_q, prev_q;

  // reset to the idle-high level so release never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q  <= 1'b1;
      ff2_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      ff1_q  <= rx_i;
      ff2_q  <= ff1_q;
      prev_q <= ff2_q;
    end
  end

  assign rx_s_o = ff2_q;
  assign fall_o = prev_q & ~ff2_q;
endmodule

// File: rtl/uart_trig_timer.sv
module uart_trig_timer #(
  parameter int DIV_W  = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              mid_o,
  output logic              wrap_o,
  output logic [SLOT_W-1:0] bits_o
);
  logic [DIV_W-1:0]  ph_q;
  logic [SLOT_W-1:0] bits_q;

  assign wrap_o = run_i && (ph_q == div_i - 1'b1);
  assign mid_o  = run_i && (bits_q == '0) && (ph_q == (div_i >> 1));
  assign bits_o = bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      bits_q <= '0;
    end else if (start_i) begin
      ph_q   <= '0;
      bits_q <= '0;
    end else if (run_i) begin
      if (wrap_o) begin
        ph_q   <= '0;
        bits_q <= bits_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_bit_trigger.sv
module uart_bit_trigger
  import uart_trig_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       data_code_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  input  logic [3:0]       target_i,
  output logic             trig_o,
  output logic [1:0]       status_o
);
  state_e            st_q;
  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] tgt_q;
  logic              rx_s, fall, mid, wrap, start, run;
  logic [SLOT_W-1:0] bits;
  logic [SLOT_W-1:0] slots, tgt_eff;

  uart_trig_sync u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .rx_s_o(rx_s),  .fall_o(fall)
  );

  assign start = (st_q == ST_ARMED) && fall && !arm_i && !disarm_i;
  assign run   = (st_q == ST_CONFIRM) || (st_q == ST_BUSY);

  uart_trig_timer #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .start_i(start), .run_i(run),
    .div_i (div_q), .mid_o(mid), .wrap_o(wrap), .bits_o(bits)
  );

  // slot count: start + (5+code) data + parity + (1+two) stop
  assign slots = SLOT_W'(7) + SLOT_W'(data_code_i) + SLOT_W'(parity_en_i)
               + SLOT_W'(two_stop_i);
  always_comb begin
    if (target_i == '0)        tgt_eff = SLOT_W'(1);
    else if (target_i > slots) tgt_eff = slots;
    else                       tgt_eff = target_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      div_q  <= '0;
      tgt_q  <= '0;
      trig_o <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      if (disarm_i) begin
        st_q <= ST_IDLE;
      end else if (arm_i) begin
        st_q  <= ST_ARMED;
        div_q <= div_i;
        tgt_q <= tgt_eff;
      end else begin
        unique case (st_q)
          ST_ARMED:   if (fall) st_q <= ST_CONFIRM;
          ST_CONFIRM: if (mid)  st_q <= rx_s ? ST_ARMED : ST_BUSY;
          ST_BUSY: begin
            if (wrap && (bits + 1'b1 == tgt_q)) begin
              trig_o <= 1'b1;
              st_q   <= ST_FIRED;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE:             status_o = STAT_IDLE;
      ST_ARMED:            status_o = STAT_ARMED;
      ST_CONFIRM, ST_BUSY: status_o = STAT_BUSY;
      default:             status_o = STAT_FIRED;
    endcase
  end
endmodule

// File: rtl/uart_trig_chk.sv
module uart_trig_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arm_i,
  input logic       disarm_i,
  input logic       trig_o,
  input logic [1:0] status_o
);
  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r4_fired_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> status_o == 2'd3);

  a_r2_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !disarm_i) |=> status_o == 2'd1);

  a_r9_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> (status_o == 2'd0) && !trig_o);

  a_r11_fire_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> $past(status_o) == 2'd2);

  a_r8_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0 || status_o == 2'd3) |=> !trig_o);
endmodule

bind uart_bit_trigger uart_trig_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .disarm_i(disarm_i),
  .trig_o(trig_o), .status_o(status_o)
);

// File: tb/sim_uart_bit_trigger.sv
module sim_uart_bit_trigger;
  localparam int DW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, arm = 1'b0, disarm = 1'b0;
  logic [DW-1:0] dv = '0;
  logic [1:0] dcode = '0;
  logic par = 1'b0, two = 1'b0;
  logic [3:0] tgt = '0;
  logic trig;
  logic [1:0] status;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_bit_trigger #(.DIV_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .arm_i(arm), .disarm_i(disarm),
    .div_i(dv), .data_code_i(dcode), .parity_en_i(par), .two_stop_i(two),
    .target_i(tgt), .trig_o(trig), .status_o(status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input int d, input int c, input int p, input int t2, input int tg);
    dv = DW'(d); dcode = 2'(c); par = p[0]; two = t2[0]; tgt = 4'(tg);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // drive one frame from the current negedge; count cycles to the trigger
  task automatic run_frame(input int d, input int slots, input int nstop,
                           output int first, output int pulses);
    first = -1; pulses = 0;
    fork
      begin
        for (int s = 0; s < slots; s++) begin
          rx = (s == 0) ? 1'b0 : (s >= slots - nstop) ? 1'b1 : s[0];
          repeat (d) @(negedge clk);
        end
        rx = 1'b1;
        repeat (2 * d + 4) @(negedge clk);
      end
      begin
        for (int c = 1; c <= (slots + 2) * d + 4; c++) begin
          @(negedge clk);
          if (trig) begin
            pulses++;
            if (first < 0) first = c;
          end
        end
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int first, pulses, slots, keff;
    int divs[3] = '{4, 5, 8};
    int fc[4] = '{3, 0, 2, 3};
    int fp[4] = '{1, 0, 0, 1};
    int ft[4] = '{0, 0, 1, 1};

    repeat (3) @(negedge clk);
    check(trig == 1'b0 && status == 2'd0, "R1 reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: line activity while idle
    run_frame(4, 11, 1, first, pulses);
    check(pulses == 0 && status == 2'd0, "R8 idle ignores line", pulses, 0);

    // R2: arm, then arm+disarm together
    do_arm(4, 3, 1, 0, 10);
    check(status == 2'd1, "R2 armed", status, 1);
    arm = 1'b1; disarm = 1'b1;
    @(negedge clk);
    arm = 1'b0; disarm = 1'b0;
    check(status == 2'd0, "R2 disarm wins", status, 0);

    // R5 R6 R3 R4: sweep divisors, formats, targets
    foreach (divs[i]) foreach (fc[j]) for (int t = 0; t < 16; t++) begin
      slots = 7 + fc[j] + fp[j] + ft[j];
      keff = (t == 0) ? 1 : (t > slots) ? slots : t;
      do_arm(divs[i], fc[j], fp[j], ft[j], t);
      run_frame(divs[i], slots, 1 + ft[j], first, pulses);
      check(first == 3 + keff * divs[i], "R3 R5 R6 trigger cycle", first, 3 + keff * divs[i]);
      check(pulses == 1, "R4 single pulse", pulses, 1);
      check(status == 2'd3, "R4 fired status", status, 3);
    end

    // R8: fired ignores a further frame
    run_frame(5, 11, 1, first, pulses);
    check(pulses == 0 && status == 2'd3, "R8 fired ignores line", pulses, 0);

    // R7: short glitch rejected, then a real frame fires
    do_arm(8, 3, 1, 0, 10);
    rx = 1'b0; @(negedge clk); rx = 1'b1;
    repeat (16) @(negedge clk);
    check(status == 2'd1 && trig == 1'b0, "R7 glitch rejected", status, 1);
    run_frame(8, 11, 1, first, pulses);
    check(first == 3 + 10 * 8 && pulses == 1, "R7 real frame after glitch", first, 83);

    // R10: change inputs after arming
    do_arm(5, 3, 1, 0, 3);
    dv = 4'd9; tgt = 4'd9; dcode = 2'd0;
    run_frame(5, 11, 1, first, pulses);
    check(first == 3 + 3 * 5, "R10 config latched", first, 18);

    // R11 and R9: busy mid-frame, then abort
    do_arm(6, 3, 1, 0, 10);
    rx = 1'b0;
    repeat (8) @(negedge clk);
    check(status == 2'd2, "R11 busy during frame", status, 2);
    rx = 1'b1;
    repeat (4) @(negedge clk);
    disarm = 1'b1; @(negedge clk); disarm = 1'b0;
    pulses = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (trig) pulses++;
    end
    check(pulses == 0 && status == 2'd0, "R9 abort no trigger", pulses, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule